// File: doc/BRIEF.md
# Circular Rotate Unit with Word Forms

This block is a purely combinational barrel rotator for an integer execution pipeline. It rotates one operand left or right by a variable amount. Bits that leave one end of the value come back in at the other end. The amount is taken from a second register operand or from a 6-bit immediate, selected by a single control bit. The datapath width `XLEN` is a parameter and may be 32 or 64.

With `XLEN` = 64, a word-form control restricts the rotation to the low 32 bits of the operand. It uses only the low five amount bits and sign-extends the 32-bit result from bit 31 into the upper half. With `XLEN` = 32, two cases are reserved encodings: an immediate amount with bit 5 set, and any word-form request. The unit raises a reserved flag in those cases and leaves the decision about them to the decoder. The unit never raises an exception itself. The result is valid in the same cycle as the inputs. A surrounding pipeline register, if one is needed, lives outside.

Top module: `rot_unit`

## Requirements
- R1: With `left_i`=0, `word_i`=0 and `use_imm_i`=0, `res_o` equals `opa_i` rotated right by k, where k is `opb_i[log2(XLEN)-1:0]` (6 bits at XLEN=64, 5 bits at XLEN=32).
- R2: With `left_i`=1 and `word_i`=0, `res_o` equals `opa_i` rotated left by the same masked amount k.
- R3: With `use_imm_i`=1, the amount is `imm_i[log2(XLEN)-1:0]`, and `opb_i` has no effect on `res_o`. The same masking applies as for the register amount.
- R4: At XLEN=64 with `word_i`=1, `res_o[31:0]` is `opa_i[31:0]` rotated in the selected direction by the low 5 bits of the selected amount source. `opa_i[63:32]` and amount bit 5 have no effect.
- R5: At XLEN=64 with `word_i`=1, every bit of `res_o[63:32]` equals `res_o[31]`.
- R6: A masked amount of zero returns `opa_i` unchanged. For word forms it returns `opa_i[31:0]` sign-extended from bit 31.
- R7: At XLEN=32, `rsvd_o` is 1 when `use_imm_i`=1 and `imm_i[5]`=1. The result still uses `imm_i[4:0]` as the amount.
- R8: At XLEN=32, `rsvd_o` is 1 whenever `word_i`=1. The result equals the full-width rotation for that amount and direction.
- R9: At XLEN=64, `rsvd_o` is always 0.
- R10: Bits of `opb_i` above the masked amount field have no effect on `res_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | XLEN | Operand to rotate |
| opb_i | input | XLEN | Register amount source; only its low log2(XLEN) bits are used |
| imm_i | input | 6 | Immediate amount source |
| use_imm_i | input | 1 | 1 selects `imm_i` as the amount, 0 selects `opb_i` |
| left_i | input | 1 | 1 rotates left, 0 rotates right |
| word_i | input | 1 | Word form: rotate the low 32 bits and sign-extend the result |
| res_o | output | XLEN | Rotated result |
| rsvd_o | output | 1 | Reserved-encoding indication |

## Verification
The bench sweeps every amount in both directions, for both register and immediate sources, through a 64-bit and a 32-bit instance. It compares each result with a reference that doubles the operand and slices it.

An amount of zero catches rotators that wrap the left-conversion wrongly: such a design returns a value rotated by the full width, or garbage, instead of the operand. Immediates with bit 5 set expose a 32-bit unit that forgets to mask the amount, and one that fails to flag the reserved case. Register amounts with random upper bits expose a unit that forgets the masking on that path.

Word-form patterns place different bits in the upper half and at bit 31. A design that rotates all 64 bits, that zero-extends the result, or that extends from the wrong bit then produces visibly wrong upper halves.

// File: rtl/rot_pkg.sv
package rot_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned WORD_SHW = 5;
  localparam int unsigned IMM_W    = 6;

  function automatic logic [63:0] sext_word(input logic [WORD_W-1:0] w);
    return {{(64-WORD_W){w[WORD_W-1]}}, w};
  endfunction
endpackage

// File: rtl/rot_amt_sel.sv
module rot_amt_sel
  import rot_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  localparam int unsigned SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0]     opb_i,
  input  logic [IMM_W-1:0]    imm_i,
  input  logic                use_imm_i,
  input  logic                left_i,
  input  logic                word_i,
  output logic [SHW-1:0]      amt_full_o,
  output logic [WORD_SHW-1:0] amt_word_o,
  output logic                rsvd_o
);
  logic [SHW-1:0] raw;
  logic           unused_opb;

  assign raw        = use_imm_i ? imm_i[SHW-1:0] : opb_i[SHW-1:0];
  assign unused_opb = ^opb_i[XLEN-1:SHW];

  // left rotate by k == right rotate by (width - k) mod width
  always_comb begin
    amt_full_o = left_i ? (~raw + 1'b1) : raw;
    amt_word_o = left_i ? (~raw[WORD_SHW-1:0] + 1'b1) : raw[WORD_SHW-1:0];
  end

  generate
    if (XLEN == 32) begin : g_rsvd32
      assign rsvd_o = (use_imm_i & imm_i[IMM_W-1]) | word_i;
    end else begin : g_rsvd64
      logic unused_word;
      assign unused_word = word_i;
      assign rsvd_o      = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/rot_barrel.sv
module rot_barrel #(
  parameter int unsigned W = 64,
  localparam int unsigned SHW = $clog2(W)
) (
  input  logic [W-1:0]   data_i,
  input  logic [SHW-1:0] amt_i,
  output logic [W-1:0]   data_o
);
  logic [W-1:0] stage [SHW+1];

  assign stage[0] = data_i;

  generate
    for (genvar s = 0; s < SHW; s++) begin : g_stage
      localparam int unsigned D = 1 << s;
      assign stage[s+1] = amt_i[s] ? {stage[s][D-1:0], stage[s][W-1:D]} : stage[s];
    end
  endgenerate

  assign data_o = stage[SHW];
endmodule

// File: rtl/rot_unit.sv
module rot_unit
  import rot_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0]  opa_i,
  input  logic [XLEN-1:0]  opb_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             use_imm_i,
  input  logic             left_i,
  input  logic             word_i,
  output logic [XLEN-1:0]  res_o,
  output logic             rsvd_o
);
  localparam int unsigned SHW = $clog2(XLEN);

  logic [SHW-1:0]      amt_full;
  logic [WORD_SHW-1:0] amt_word;
  logic [XLEN-1:0]     full_res;

  rot_amt_sel #(.XLEN(XLEN)) u_amt (
    .opb_i      (opb_i),
    .imm_i      (imm_i),
    .use_imm_i  (use_imm_i),
    .left_i     (left_i),
    .word_i     (word_i),
    .amt_full_o (amt_full),
    .amt_word_o (amt_word),
    .rsvd_o     (rsvd_o)
  );

  rot_barrel #(.W(XLEN)) u_full (
    .data_i (opa_i),
    .amt_i  (amt_full),
    .data_o (full_res)
  );

  generate
    if (XLEN == 64) begin : g_word
      logic [WORD_W-1:0] word_res;
      rot_barrel #(.W(WORD_W)) u_word (
        .data_i (opa_i[WORD_W-1:0]),
        .amt_i  (amt_word),
        .data_o (word_res)
      );
      assign res_o = word_i ? sext_word(word_res) : full_res;
    end else begin : g_noword
      // 32-bit word form is the full rotation; flagged as reserved
      logic unused_amt;
      assign unused_amt = ^amt_word;
      assign res_o      = full_res;
    end
  endgenerate
endmodule

// File: rtl/rot_unit_chk.sv
module rot_unit_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic [XLEN-1:0] opa_i,
  input logic [XLEN-1:0] opb_i,
  input logic [5:0]      imm_i,
  input logic            use_imm_i,
  input logic            left_i,
  input logic            word_i,
  input logic [XLEN-1:0] res_o,
  input logic            rsvd_o
);
  localparam int unsigned SHW = $clog2(XLEN);

  logic [SHW-1:0] k;
  assign k = use_imm_i ? imm_i[SHW-1:0] : opb_i[SHW-1:0];

  generate
    if (XLEN == 64) begin : g_c64
      always_comb begin
        assert_no_rsvd_R9: assert (!rsvd_o);
        if (word_i) begin
          assert_word_sext_R5: assert (res_o[63:32] == {32{res_o[31]}});
          // R4: word rotation keeps the low word's ones count
          assert_word_pop_R4: assert ($countones(res_o[31:0]) == $countones(opa_i[31:0]));
          if (k[4:0] == 5'd0)
            assert_word_zero_R6: assert (res_o[31:0] == opa_i[31:0]);
        end else begin
          // R1/R2: rotation preserves the ones count
          assert_full_pop_R1: assert ($countones(res_o) == $countones(opa_i));
          if (k == '0)
            assert_full_zero_R6: assert (res_o == opa_i);
        end
      end
    end else begin : g_c32
      always_comb begin
        assert_full_pop_R2: assert ($countones(res_o) == $countones(opa_i));
        if (k == '0)
          assert_zero_amt_R6: assert (res_o == opa_i);
        if (use_imm_i && imm_i[5])
          assert_rsvd_imm_R7: assert (rsvd_o);
        if (word_i)
          assert_rsvd_word_R8: assert (rsvd_o);
        if (!word_i && !(use_imm_i && imm_i[5]))
          assert_rsvd_clear_R7: assert (!rsvd_o);
      end
    end
  endgenerate
endmodule

bind rot_unit rot_unit_chk #(.XLEN(XLEN)) u_chk (
  .opa_i     (opa_i),
  .opb_i     (opb_i),
  .imm_i     (imm_i),
  .use_imm_i (use_imm_i),
  .left_i    (left_i),
  .word_i    (word_i),
  .res_o     (res_o),
  .rsvd_o    (rsvd_o)
);

// File: tb/rot_unit_bench.sv
`timescale 1ns/1ps
module rot_unit_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [63:0] opa, opb;
  logic [5:0]  imm;
  logic        use_imm, left, word;
  logic [63:0] res64;
  logic        rsvd64;
  logic [31:0] res32;
  logic        rsvd32;

  rot_unit #(.XLEN(64)) u_rot_unit (
    .opa_i(opa), .opb_i(opb), .imm_i(imm), .use_imm_i(use_imm),
    .left_i(left), .word_i(word), .res_o(res64), .rsvd_o(rsvd64)
  );

  rot_unit #(.XLEN(32)) u_rot_unit_w32 (
    .opa_i(opa[31:0]), .opb_i(opb[31:0]), .imm_i(imm), .use_imm_i(use_imm),
    .left_i(left), .word_i(word), .res_o(res32), .rsvd_o(rsvd32)
  );

  typedef struct packed {
    logic [63:0] e64;
    logic        r64;
    logic [31:0] e32;
    logic        r32;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 1'b0;

  function automatic logic [63:0] ref64(input logic [63:0] a, input int k, input bit l);
    logic [127:0] d = {a, a};
    if (l) begin d = d << k; return d[127:64]; end
    d = d >> k;
    return d[63:0];
  endfunction

  function automatic logic [31:0] ref32(input logic [31:0] a, input int k, input bit l);
    logic [63:0] d = {a, a};
    if (l) begin d = d << k; return d[63:32]; end
    d = d >> k;
    return d[31:0];
  endfunction

  task automatic drive(input logic [63:0] a, input logic [63:0] b, input logic [5:0] im,
                       input bit ui, input bit l, input bit w, input string tag);
    exp_t e;
    logic [5:0] k64;
    logic [4:0] k32;
    logic [31:0] wr;
    @(posedge clk);
    #1;
    opa = a; opb = b; imm = im; use_imm = ui; left = l; word = w;
    k64 = ui ? im : b[5:0];
    k32 = ui ? im[4:0] : b[4:0];
    if (w) begin
      wr = ref32(a[31:0], int'(k64[4:0]), l);
      e.e64 = {{32{wr[31]}}, wr};
    end else begin
      e.e64 = ref64(a, int'(k64), l);
    end
    e.r64 = 1'b0;
    e.e32 = ref32(a[31:0], int'(k32), l);
    e.r32 = w | (ui & im[5]);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor: compares away from the driving edge
  always @(negedge clk) begin
    if (rst_ni && exp_q.size() > 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_tests += 2;
      if (res64 !== e.e64 || rsvd64 !== e.r64) begin
        n_fail++;
        $display("FAIL %s xlen64: res=%h rsvd=%b expected res=%h rsvd=%b",
                 t, res64, rsvd64, e.e64, e.r64);
      end
      if (res32 !== e.e32 || rsvd32 !== e.r32) begin
        n_fail++;
        $display("FAIL %s xlen32: res=%h rsvd=%b expected res=%h rsvd=%b",
                 t, res32, rsvd32, e.e32, e.r32);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] pat [6];
    pat[0] = 64'h0000_0000_0000_0001;
    pat[1] = 64'h8000_0000_0000_0000;
    pat[2] = 64'hDEAD_BEEF_0123_4567;
    pat[3] = 64'hF0E1_D2C3_B4A5_9687;
    pat[4] = 64'h1234_5678_8000_0001;
    pat[5] = 64'hFFFF_FFFF_7FFF_FFF0;
    opa = '0; opb = '0; imm = '0; use_imm = 1'b0; left = 1'b0; word = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // quiescent inputs after reset: zero operand, zero amount
    drive(64'h0, 64'h0, 6'h0, 1'b0, 1'b0, 1'b0, "R6 reset");
    for (int p = 0; p < 6; p++) begin
      for (int k = 0; k < 64; k++) begin
        for (int d = 0; d < 2; d++) begin
          logic [63:0] b;
          b = {$urandom, $urandom};
          b[5:0] = 6'(k);
          drive(pat[p], b, 6'($urandom), 1'b0, d[0], 1'b0,
                k == 0 ? "R6 R10" : (d == 0 ? "R1 R10" : "R2 R10"));
          drive(pat[p], {$urandom, $urandom}, 6'(k), 1'b1, d[0], 1'b0,
                k >= 32 ? "R3 R7 R9" : "R3 R9");
          drive(pat[p], b, 6'($urandom), 1'b0, d[0], 1'b1,
                k % 32 == 0 ? "R4 R5 R6 R8" : "R4 R5 R8");
          drive(pat[p], {$urandom, $urandom}, 6'(k), 1'b1, d[0], 1'b1, "R4 R5 R7 R8");
        end
      end
    end
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule